// File: doc/BRIEF.md
# Status Register Write Protection Unit

This block owns the protection state of a serial nonvolatile memory: a volatile write-enable latch and a status register that holds a protect-enable flag and a two-bit block-protect field. A command decoder, which is outside the block, sends it one-cycle strobes for write-enable set, write-enable reset, status write with a data byte, and array write with an address. The block answers in the same cycle with an allow signal for the array write or for the status write. It also provides the status byte for status reads.

The hardware protect pin is active low. It locks only the status register, and only while the protect-enable flag is set. Array writes are guarded by the latch and by the block-protect field. The pin never refuses an array write directly. The latch is volatile. It drops when chip select is released after any session that carried an array write or a status write strobe. The serial shifter and the memory array are not part of this block.

Top module: `wpu_top`

## Requirements
- R1: After reset, the status byte reads 8'h00 and neither allow output is high.
- R2: A set strobe makes the latch 1 and a reset strobe makes it 0. The latch reads back in status bit 1 from the cycle after the strobe.
- R3: While the latch is 0, every array write and every status write is refused.
- R4: Block-protect field status[3:2] works as follows. 00 protects nothing. 01 refuses array writes to 13'h1800..13'h1FFF. 10 refuses array writes to 13'h1000..13'h1FFF. 11 refuses array writes to every address.
- R5: A status write is refused when status bit 7 is 1 and the protect pin is low. It is allowed when the latch is 1 and either condition is absent.
- R6: The protect pin level never changes whether an array write is allowed.
- R7: An allowed status write loads data bits 7, 3 and 2 into the status byte in the next cycle. Status bits 6:4 and bit 0 always read 0, and bit 1 is not written by data.
- R8: A rising chip select clears the latch when the session held at least one array write or status write strobe. A session that held neither leaves the latch unchanged.
- R9: A reset strobe takes priority over a set strobe in the same cycle.
- R10: The allow outputs reflect the current cycle's strobes and the state held from earlier cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wel_set_i | input | 1 | Write-enable set strobe |
| wel_clr_i | input | 1 | Write-enable reset strobe |
| sr_wr_i | input | 1 | Status write strobe |
| sr_data_i | input | 8 | Status write data byte |
| arr_wr_i | input | 1 | Array write strobe |
| arr_addr_i | input | 13 | Array write byte address |
| wp_n_i | input | 1 | Hardware protect pin, active low |
| cs_n_i | input | 1 | Chip select, active low |
| status_o | output | 8 | Status byte {pe,000,bp[1:0],wel,0} |
| arr_wr_ok_o | output | 1 | Array write allowed this cycle |
| sr_wr_ok_o | output | 1 | Status write allowed this cycle |

## Verification
The hardest state to reach is a locked status register that is still latch-enabled. Getting there requires a status write that sets the protect flag, then a chip select release, then a fresh set strobe, and only then a pin-low status write. Random stimulus seldom lines these steps up. The bench therefore drives that sequence directly, and it also walks the block-protect boundaries at 13'h0FFF/13'h1000 and 13'h17FF/13'h1800. It then runs a seeded random mix of strobes, pin levels and chip select releases against a reference model in the bench.

// File: rtl/wpu_pkg.sv
package wpu_pkg;

    typedef enum logic [1:0] {
        BP_NONE    = 2'b00,
        BP_QUARTER = 2'b01,
        BP_HALF    = 2'b10,
        BP_ALL     = 2'b11
    } bp_e;

    typedef struct packed {
        logic pe;
        bp_e  bp;
        logic wel;
        logic cs_n;
    } wpu_state_t;

    localparam int unsigned ST_PE  = 7;
    localparam int unsigned ST_BP1 = 3;
    localparam int unsigned ST_BP0 = 2;
    localparam int unsigned ST_WEL = 1;

endpackage

// File: rtl/wpu_region.sv
module wpu_region #(
    parameter int unsigned ADDR_W = 13
) (
    input  wpu_pkg::bp_e       bp_i,
    input  logic [ADDR_W-1:0]  addr_i,
    output logic               prot_o
);
    import wpu_pkg::*;

    localparam int unsigned TOP = ADDR_W - 1;

    always_comb begin
        unique case (bp_i)
            BP_NONE:    prot_o = 1'b0;
            BP_QUARTER: prot_o = addr_i[TOP] & addr_i[TOP-1];
            BP_HALF:    prot_o = addr_i[TOP];
            default:    prot_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/wpu_session.sv
module wpu_session (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_i,
    input  logic cs_n_q_i,
    input  logic wr_seen_i,
    output logic end_wr_o
);
    logic seen_d, seen_q;
    logic rise;

    always_comb begin
        rise     = cs_n_i & ~cs_n_q_i;
        end_wr_o = rise & (seen_q | wr_seen_i);
        seen_d   = rise ? 1'b0 : (seen_q | wr_seen_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= seen_d;
    end

    // R8: a session end with a recorded write leaves no stale mark behind
    p_seen_cleared_r8: assert property (@(posedge clk) disable iff (!rst_n)
        end_wr_o |=> !seen_q);
endmodule

// File: rtl/wpu_top.sv
module wpu_top #(
    parameter int unsigned ADDR_W = 13,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wel_set_i,
    input  logic              wel_clr_i,
    input  logic              sr_wr_i,
    input  logic [DATA_W-1:0] sr_data_i,
    input  logic              arr_wr_i,
    input  logic [ADDR_W-1:0] arr_addr_i,
    input  logic              wp_n_i,
    input  logic              cs_n_i,
    output logic [DATA_W-1:0] status_o,
    output logic              arr_wr_ok_o,
    output logic              sr_wr_ok_o
);
    import wpu_pkg::*;

    wpu_state_t st_d, st_q;
    logic       prot;
    logic       end_wr;
    logic       sr_locked;

    wpu_region #(.ADDR_W(ADDR_W)) i_region (
        .bp_i   (st_q.bp),
        .addr_i (arr_addr_i),
        .prot_o (prot)
    );

    wpu_session i_session (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n_i    (cs_n_i),
        .cs_n_q_i  (st_q.cs_n),
        .wr_seen_i (arr_wr_i | sr_wr_i),
        .end_wr_o  (end_wr)
    );

    always_comb begin
        st_d        = st_q;
        sr_locked   = st_q.pe & ~wp_n_i;
        arr_wr_ok_o = arr_wr_i & st_q.wel & ~prot;
        sr_wr_ok_o  = sr_wr_i & st_q.wel & ~sr_locked;

        status_o         = '0;
        status_o[ST_PE]  = st_q.pe;
        status_o[ST_BP1] = st_q.bp[1];
        status_o[ST_BP0] = st_q.bp[0];
        status_o[ST_WEL] = st_q.wel;

        if (sr_wr_ok_o) begin
            st_d.pe = sr_data_i[ST_PE];
            st_d.bp = bp_e'({sr_data_i[ST_BP1], sr_data_i[ST_BP0]});
        end

        if (end_wr || wel_clr_i) st_d.wel = 1'b0;
        else if (wel_set_i)      st_d.wel = 1'b1;

        st_d.cs_n = cs_n_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{pe: 1'b0, bp: BP_NONE, wel: 1'b0, cs_n: 1'b1};
        else        st_q <= st_d;
    end

    p_latch_gates_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_wr_ok_o || sr_wr_ok_o) |-> status_o[ST_WEL]);

    p_full_protect_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_wr_i && status_o[ST_BP1] && status_o[ST_BP0]) |-> !arr_wr_ok_o);

    p_pin_lock_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_wr_i && status_o[ST_PE] && !wp_n_i) |-> !sr_wr_ok_o);

    p_sr_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sr_wr_ok_o |=> (status_o[ST_PE] == $past(sr_data_i[ST_PE]))
                    && (status_o[ST_BP1] == $past(sr_data_i[ST_BP1]))
                    && (status_o[ST_BP0] == $past(sr_data_i[ST_BP0])));

    p_refused_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !sr_wr_ok_o |=> $stable(status_o[ST_PE]) && $stable(status_o[ST_BP1])
                     && $stable(status_o[ST_BP0]));

    p_end_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        end_wr |=> !status_o[ST_WEL]);

    p_clr_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wel_clr_i |=> !status_o[ST_WEL]);
endmodule

// File: tb/test_wpu_top.sv
module test_wpu_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wel_set_i = 1'b0, wel_clr_i = 1'b0, sr_wr_i = 1'b0, arr_wr_i = 1'b0;
    logic [7:0]  sr_data_i = '0;
    logic [12:0] arr_addr_i = '0;
    logic        wp_n_i = 1'b1, cs_n_i = 1'b1;
    logic [7:0]  status_o;
    logic        arr_wr_ok_o, sr_wr_ok_o;

    int checks = 0;
    int errors = 0;

    logic m_pe = 1'b0, m_wel = 1'b0, m_seen = 1'b0, m_csq = 1'b1;
    logic [1:0] m_bp = 2'b00;

    always #4 clk = ~clk;

    wpu_top i_wpu_top (
        .clk(clk), .rst_n(rst_n), .wel_set_i(wel_set_i), .wel_clr_i(wel_clr_i),
        .sr_wr_i(sr_wr_i), .sr_data_i(sr_data_i), .arr_wr_i(arr_wr_i),
        .arr_addr_i(arr_addr_i), .wp_n_i(wp_n_i), .cs_n_i(cs_n_i),
        .status_o(status_o), .arr_wr_ok_o(arr_wr_ok_o), .sr_wr_ok_o(sr_wr_ok_o)
    );

    function automatic logic exp_prot(logic [1:0] bp, logic [12:0] a);
        case (bp)
            2'b00:   return 1'b0;
            2'b01:   return a >= 13'h1800;
            2'b10:   return a >= 13'h1000;
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic [7:0] exp_status();
        return {m_pe, 3'b000, m_bp, m_wel, 1'b0};
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one cycle at the negedge, check the outputs, and advance the model at the posedge.
    task automatic step(logic set, logic clr, logic sw, logic [7:0] d,
                        logic aw, logic [12:0] a, logic wp, logic cs, string req);
        logic e_aok, e_sok, rise;
        wel_set_i = set; wel_clr_i = clr; sr_wr_i = sw; sr_data_i = d;
        arr_wr_i = aw; arr_addr_i = a; wp_n_i = wp; cs_n_i = cs;
        #1;
        e_aok = aw & m_wel & ~exp_prot(m_bp, a);
        e_sok = sw & m_wel & ~(m_pe & ~wp);
        check({req, " R10 status"}, status_o, exp_status());
        check({req, " R4 arr_ok"}, {7'b0, arr_wr_ok_o}, {7'b0, e_aok});
        check({req, " R5 sr_ok"}, {7'b0, sr_wr_ok_o}, {7'b0, e_sok});
        rise = cs & ~m_csq;
        if (e_sok) begin m_pe = d[7]; m_bp = d[3:2]; end
        if (rise && (m_seen | aw | sw)) m_wel = 1'b0;
        else if (clr)                   m_wel = 1'b0;
        else if (set)                   m_wel = 1'b1;
        m_seen = rise ? 1'b0 : (m_seen | aw | sw);
        m_csq = cs;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle(logic cs, string req);
        step(0, 0, 0, 8'h00, 0, 13'h0, 1'b1, cs, req);
    endtask

    task automatic set_status(logic [7:0] d, string req);
        idle(0, req);
        step(1, 0, 0, 8'h00, 0, 13'h0, 1'b1, 0, req);
        idle(1, req);
        idle(0, req);
        step(0, 0, 1, d, 0, 13'h0, 1'b1, 0, req);
        idle(1, req);
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        @(negedge clk);
        #1;
        check("R1 reset status", status_o, 8'h00);
        check("R1 reset allows", {6'b0, arr_wr_ok_o, sr_wr_ok_o}, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R3: writes refused with the latch clear
        idle(0, "R3");
        step(0, 0, 0, 8'h00, 1, 13'h0010, 1'b1, 0, "R3 arr");
        step(0, 0, 1, 8'h8C, 0, 13'h0, 1'b1, 0, "R3 sr");
        idle(1, "R3");
        check("R3 status unchanged", status_o, 8'h00);

        // R2 and R9
        idle(0, "R2");
        step(1, 0, 0, 8'h00, 0, 13'h0, 1'b1, 0, "R2 set");
        check("R2 latch set", status_o, 8'h02);
        step(0, 1, 0, 8'h00, 0, 13'h0, 1'b1, 0, "R2 clr");
        check("R2 latch clr", status_o, 8'h00);
        step(1, 1, 0, 8'h00, 0, 13'h0, 1'b1, 0, "R9 both");
        check("R9 clear wins", status_o, 8'h00);

        // R8: a session without write keeps the latch
        step(1, 0, 0, 8'h00, 0, 13'h0, 1'b1, 0, "R8 set");
        idle(1, "R8");
        check("R8 no-write session keeps latch", status_o, 8'h02);
        idle(0, "R8");
        step(0, 0, 0, 8'h00, 1, 13'h0100, 1'b0, 0, "R6 pin low arr ok");
        idle(1, "R8");
        check("R8 write session clears latch", status_o, 8'h00);

        // R7: status write loads only bits 7,3,2
        set_status(8'hFF, "R7");
        check("R7 load masked", status_o, 8'h8C);

        // R5: locked status register with the latch set
        idle(0, "R5");
        step(1, 0, 0, 8'h00, 0, 13'h0, 1'b1, 0, "R5 set");
        step(0, 0, 1, 8'h00, 0, 13'h0, 1'b0, 0, "R5 locked");
        check("R5 lock kept status", status_o, 8'h8E);
        step(0, 0, 0, 8'h00, 1, 13'h0000, 1'b0, 0, "R6 bp11 refuse");
        step(0, 0, 1, 8'h04, 0, 13'h0, 1'b1, 0, "R5 pin high");
        check("R5 unlocked load", status_o, 8'h06);
        idle(1, "R5");

        // R4 boundaries
        for (int bp = 0; bp < 4; bp++) begin
            set_status({6'b0, bp[1:0]} << 2, "R4 cfg");
            idle(0, "R4");
            step(1, 0, 0, 8'h00, 0, 13'h0, 1'b1, 0, "R4 set");
            step(0, 0, 0, 8'h00, 1, 13'h0FFF, 1'b0, 0, "R4 0FFF");
            step(0, 0, 0, 8'h00, 1, 13'h1000, 1'b1, 0, "R4 1000");
            step(0, 0, 0, 8'h00, 1, 13'h17FF, 1'b0, 0, "R4 17FF");
            step(0, 0, 0, 8'h00, 1, 13'h1800, 1'b1, 0, "R4 1800");
            step(0, 0, 0, 8'h00, 1, 13'h1FFF, 1'b1, 0, "R4 1FFF");
            idle(1, "R4");
        end

        // Random mix
        for (int i = 0; i < 3000; i++) begin
            int unsigned op = $urandom_range(0, 9);
            logic [12:0] a = 13'($urandom);
            logic [7:0]  d = 8'($urandom);
            logic        wp = ($urandom_range(0, 2) != 0);
            logic        cs = ($urandom_range(0, 5) == 0);
            step(op == 0 || op == 1, op == 2, op == 3 || op == 4, d,
                 op >= 5 && op <= 7, a, wp, cs, "rand");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule